// File: doc/BRIEF.md
# Integer ALU with Signed Compare and Overflow Flag

This block is the arithmetic and logic unit of a simple load/store processor datapath. It takes two operands of `WIDTH` bits (32 by default) and produces a bitwise AND, a bitwise OR, a sum, a difference, or a signed "less than" indication. It also produces a zero flag and a signed overflow flag. The whole block is combinational, so its outputs follow its inputs within the same cycle.

The operation is not chosen directly. The main control unit supplies a 2-bit operation class. For register-to-register instructions, the instruction's 6-bit function field is also supplied. A small decoder inside the block turns these into an internal 3-bit control word: a negate bit and a 2-bit unit select. The negate bit has two jobs. It inverts operand B, and it is also the carry into bit 0 of the ripple adder, so a subtraction is computed as A plus the inverted B plus one.

The signed compare does not trust the raw sign of the difference. It takes the sign bit of A minus B and XORs it with that subtraction's overflow. This keeps the answer correct when the subtraction wraps around.

Top module: `alu_core`

## Requirements
- R1: With operation class `10` and function bits [3:0] = `0100`, the result is A AND B.
- R2: With operation class `10` and function bits [3:0] = `0101`, the result is A OR B.
- R3: The result is (A + B) mod 2^WIDTH in two cases: operation class `00`, and operation class `10` with function bits [3:0] = `0000` or any value not listed in R1, R2, R4 or R7.
- R4: The result is (A − B) mod 2^WIDTH in two cases: operation class `01` or `11` (the low class bit set), and operation class `10` with function bits [3:0] = `0010`.
- R5: For add and subtract, the overflow output is 1 exactly when the true signed result lies outside the two's-complement range of WIDTH bits. This is the same as the carry into the sign bit differing from the carry out of it.
- R6: For AND, OR and set-less-than, the overflow output is 0.
- R7: With operation class `10` and function bits [3:0] = `1010`, result bit 0 is 1 exactly when signed A is less than signed B, and all other result bits are 0. This holds even when A − B overflows, for example the most negative value minus a positive value.
- R8: The zero output is 1 exactly when every result bit is 0.
- R9: Function bits [5:4] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aluop_i | input | 2 | Operation class from the main control |
| funct_i | input | 6 | Function field of a register-type instruction |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The block has no register between its inputs and its outputs, so every result, the zero flag and the overflow flag are due in the same cycle as the stimulus. No cycle delay is expected. The bench applies a new set of inputs just after a rising clock edge and samples all three outputs at the following falling edge, half a period later. That leaves the ripple chain time to settle and keeps the sample away from any edge. A 4-bit instance is swept over every operand pair under every control code, and a 32-bit instance covers the wrap-around compare cases.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SLT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic    b_neg;
        alu_op_e op;
    } alu_ctrl_t;

    localparam alu_ctrl_t CTRL_AND = '{b_neg: 1'b0, op: OP_AND};
    localparam alu_ctrl_t CTRL_OR  = '{b_neg: 1'b0, op: OP_OR};
    localparam alu_ctrl_t CTRL_ADD = '{b_neg: 1'b0, op: OP_ADD};
    localparam alu_ctrl_t CTRL_SUB = '{b_neg: 1'b1, op: OP_ADD};
    localparam alu_ctrl_t CTRL_SLT = '{b_neg: 1'b1, op: OP_SLT};

    localparam int FUNCT_W = 6;
    localparam int CLASS_W = 2;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
    import alu_pkg::*;
(
    input  logic [CLASS_W-1:0] aluop_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output alu_ctrl_t          ctrl_o
);

    alu_ctrl_t ctrl_d;
    logic      unused_funct_hi;

    assign unused_funct_hi = ^funct_i[FUNCT_W-1:4];

    always_comb begin
        ctrl_d = CTRL_ADD;
        if (aluop_i[0]) begin
            ctrl_d = CTRL_SUB;
        end else if (aluop_i[1]) begin
            unique case (funct_i[3:0])
                4'b0000: ctrl_d = CTRL_ADD;
                4'b0010: ctrl_d = CTRL_SUB;
                4'b0100: ctrl_d = CTRL_AND;
                4'b0101: ctrl_d = CTRL_OR;
                4'b1010: ctrl_d = CTRL_SLT;
                default: ctrl_d = CTRL_ADD;
            endcase
        end
    end

    assign ctrl_o = ctrl_d;

    always_comb begin
        if (aluop_i == 2'b00) begin
            assert_class_add_R3: assert (ctrl_o == CTRL_ADD)
                else $error("class 00 did not decode to add");
        end
        if (aluop_i[0]) begin
            assert_class_sub_R4: assert (ctrl_o == CTRL_SUB)
                else $error("low class bit did not decode to subtract");
        end
    end

endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             neg_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_msb_in_o,
    output logic             c_out_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    assign carry[0] = neg_i;
    assign b_eff    = b_i ^ {WIDTH{neg_i}};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic p_bit;
        logic g_bit_c;
        assign p_bit      = a_i[i] ^ b_eff[i];
        assign g_bit_c    = a_i[i] & b_eff[i];
        assign sum_o[i]   = p_bit ^ carry[i];
        assign carry[i+1] = g_bit_c | (p_bit & carry[i]);
    end

    assign c_msb_in_o = carry[MSB];
    assign c_out_o    = carry[WIDTH];

    always_comb begin
        assert_sum_R3: assert (sum_o == WIDTH'(a_i + b_eff + WIDTH'(neg_i)))
            else $error("ripple sum disagrees with arithmetic sum");
    end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctrl_t        ctrl_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             c_msb_in_i,
    input  logic             c_out_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             zero;
        logic             ovf;
    } out_t;

    out_t out_d;
    logic ovf_raw;
    logic less;

    always_comb begin
        ovf_raw = c_msb_in_i ^ c_out_i;
        less    = sum_i[MSB] ^ ovf_raw;
        out_d   = '0;
        unique case (ctrl_i.op)
            OP_AND: out_d.result = a_i & b_i;
            OP_OR:  out_d.result = a_i | b_i;
            OP_ADD: out_d.result = sum_i;
            OP_SLT: out_d.result = {{(WIDTH-1){1'b0}}, less};
            default: out_d.result = sum_i;
        endcase
        out_d.ovf  = (ctrl_i.op == OP_ADD) ? ovf_raw : 1'b0;
        out_d.zero = ~|out_d.result;
    end

    assign result_o = out_d.result;
    assign zero_o   = out_d.zero;
    assign ovf_o    = out_d.ovf;

    always_comb begin
        if (ctrl_i.op == OP_SLT) begin
            assert_slt_upper_zero_R7: assert (result_o[MSB:1] == '0)
                else $error("compare result has upper bits set");
        end
        if (ctrl_i.op != OP_ADD) begin
            assert_no_overflow_R6: assert (!ovf_o)
                else $error("overflow raised outside add/subtract");
        end
        if (ctrl_i == CTRL_ADD && a_i[MSB] == b_i[MSB] && sum_i[MSB] != a_i[MSB]) begin
            assert_add_overflow_R5: assert (ovf_o)
                else $error("same-sign add flipped sign without overflow");
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       aluop_i,
    input  logic [5:0]       funct_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] sum;
    logic             c_msb_in;
    logic             c_out;

    alu_ctrl_dec u_dec (
        .aluop_i (aluop_i),
        .funct_i (funct_i),
        .ctrl_o  (ctrl)
    );

    alu_ripple_add #(.WIDTH(WIDTH)) u_add (
        .a_i        (a_i),
        .b_i        (b_i),
        .neg_i      (ctrl.b_neg),
        .sum_o      (sum),
        .c_msb_in_o (c_msb_in),
        .c_out_o    (c_out)
    );

    alu_out_stage #(.WIDTH(WIDTH)) u_out (
        .ctrl_i     (ctrl),
        .a_i        (a_i),
        .b_i        (b_i),
        .sum_i      (sum),
        .c_msb_in_i (c_msb_in),
        .c_out_i    (c_out),
        .result_o   (result_o),
        .zero_o     (zero_o),
        .ovf_o      (ovf_o)
    );

    always_comb begin
        assert_zero_flag_R8: assert (zero_o == (result_o == '0))
            else $error("zero flag disagrees with result");
    end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;

    localparam int SW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks   = 0;
    int failures = 0;

    logic [1:0]    aluop;
    logic [5:0]    funct;
    logic [SW-1:0] a_s, b_s, r_s;
    logic          z_s, o_s;

    logic [WW-1:0] a_w, b_w, r_w;
    logic          z_w, o_w;

    alu_core #(.WIDTH(SW)) uut (
        .aluop_i (aluop), .funct_i (funct), .a_i (a_s), .b_i (b_s),
        .result_o(r_s), .zero_o(z_s), .ovf_o(o_s)
    );

    alu_core #(.WIDTH(WW)) uut_wide (
        .aluop_i (aluop), .funct_i (funct), .a_i (a_w), .b_i (b_w),
        .result_o(r_w), .zero_o(z_w), .ovf_o(o_w)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // kind: 0 and, 1 or, 2 add, 3 sub, 4 slt
    task automatic model(input int kind, input int a, input int b, output int r, output int ov);
        int sa, sb, sv;
        sa = (a >= 8) ? a - 16 : a;
        sb = (b >= 8) ? b - 16 : b;
        ov = 0;
        case (kind)
            0: r = a & b;
            1: r = a | b;
            2: begin r = (a + b) & 15; sv = sa + sb; ov = (sv > 7 || sv < -8) ? 1 : 0; end
            3: begin r = (a - b) & 15; sv = sa - sb; ov = (sv > 7 || sv < -8) ? 1 : 0; end
            default: r = (sa < sb) ? 1 : 0;
        endcase
    endtask

    task automatic run_small(input logic [1:0] cls, input logic [3:0] lo, input int kind, input string req);
        int r, ov;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(posedge clk);
                aluop = cls;
                funct = {2'(a + b), lo};   // R9: upper function bits vary freely
                a_s   = 4'(a);
                b_s   = 4'(b);
                @(negedge clk);
                model(kind, a, b, r, ov);
                chk(req, 64'(r_s), 64'(r));
                chk("R8 zero flag", 64'(z_s), 64'(r == 0));
                chk((kind >= 2 && kind <= 3) ? "R5 overflow" : "R6 no overflow", 64'(o_s), 64'(ov));
            end
        end
    endtask

    task automatic run_wide(input logic [1:0] cls, input logic [3:0] lo,
                            input logic [WW-1:0] a, input logic [WW-1:0] b,
                            input logic [WW-1:0] er, input logic eo, input string req);
        @(posedge clk);
        aluop = cls;
        funct = {2'b11, lo};
        a_w   = a;
        b_w   = b;
        @(negedge clk);
        chk(req, 64'(r_w), 64'(er));
        chk(req, 64'(o_w), 64'(eo));
        chk("R8 zero flag wide", 64'(z_w), 64'(er == '0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        aluop = 2'b00; funct = '0; a_s = '0; b_s = '0; a_w = '0; b_w = '0;
        @(negedge clk);
        chk("R8 reset-state zero", 64'(z_s), 64'd1);
        chk("R3 reset-state result", 64'(r_s), 64'd0);

        run_small(2'b10, 4'b0100, 0, "R1 and");
        run_small(2'b10, 4'b0101, 1, "R2 or");
        run_small(2'b10, 4'b0000, 2, "R3 add funct");
        run_small(2'b00, 4'b1111, 2, "R3 add class00");
        run_small(2'b10, 4'b0111, 2, "R3 add unlisted funct");
        run_small(2'b10, 4'b0010, 3, "R4 sub funct");
        run_small(2'b01, 4'b0100, 3, "R4 sub class01");
        run_small(2'b11, 4'b0101, 3, "R4 sub class11");
        run_small(2'b10, 4'b1010, 4, "R7 slt");

        run_wide(2'b10, 4'b1010, 32'h8000_0000, 32'h0000_0001, 32'd1, 1'b0, "R7 most-negative < positive");
        run_wide(2'b01, 4'b0000, 32'h8000_0000, 32'h0000_0001, 32'h7fff_ffff, 1'b1, "R5 wide sub overflow");
        run_wide(2'b10, 4'b1010, 32'h7fff_ffff, 32'hffff_ffff, 32'd0, 1'b0, "R7 max not < minus one");
        run_wide(2'b00, 4'b0000, 32'h7fff_ffff, 32'h0000_0001, 32'h8000_0000, 1'b1, "R5 wide add overflow");
        run_wide(2'b00, 4'b0000, 32'hffff_ffff, 32'h0000_0001, 32'd0, 1'b0, "R3 wide add wrap no overflow");
        run_wide(2'b10, 4'b1010, 32'hffff_fffe, 32'hffff_ffff, 32'd1, 1'b0, "R7 negative compare");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule